// File: doc/BRIEF.md
# Embedded Operations Channel Message Handler

This block carries 12-bit operations messages through a dedicated field of a line superframe. Each message holds a three-bit destination address, a mode flag that tells data from message content, and an eight-bit information field. In the transmit direction, a host writes one message. While the line is superframe synchronized, the block loads that message into a shift register at every half-superframe strobe and sends it one bit per bit-slot strobe. Each superframe therefore carries the message twice.

In the receive direction, the block shifts in the field bits. At every half-superframe strobe it takes the last 12 bits as one extraction. The extraction is validated either at once or only after three identical extractions in a row. When an accepted message differs from the one last shown to the host in its address or its information bits, the block presents it on a read port and raises an interrupt request. The request stays up until the host reads.

Top module: `eoc_msg_handler`

## Requirements
- R1: A message is 12 bits. Bits 11..9 are the address, with bit 11 as the first address bit. Bit 8 is the mode flag (1 = data, 0 = message). Bits 7..0 are the information bits, with bit 7 as the first. On the line the bits go in the order bit 11, 10, down to bit 0.
- R2: After reset, and for one cycle after `deact` is pulsed, the transmit message register and the transmit shift register hold all ones. The stream sent after the next half strobe is then twelve ones.
- R3: While `sync` is low, `tx_bit` is 1 and the transmit shift register is neither loaded nor shifted.
- R4: On `half_sf` with `sync` high, the transmit shift register loads the message register. `tx_bit` then shows bit 11, and each `bit_en` advances one bit, filling with ones. A host write takes effect at the next half strobe, and the same message repeats every half.
- R5: On `bit_en` with `sync` high, `rx_bit` enters the receive shift register at bit 0. At `half_sf` the extraction is the register's 12 bits, with the first-received bit at bit 11.
- R6: No extraction is made unless `half_sf`, `sync` and `eoc_en` are all high in the same cycle. While `sync` is low the confirmation count clears.
- R7: With `val_mode` = 0, every extraction is accepted.
- R8: With `val_mode` = 1, an extraction is accepted only when it is the third identical extraction in a row. Any differing extraction restarts the count at one.
- R9: An accepted message is presented on `rd_data`, and `irq` is raised one cycle after the half strobe, only if its bits 11..9 or 7..0 differ from the last presented message. A change in bit 8 alone is ignored. After reset the presented message is all ones.
- R10: `irq` stays high until `rd_en`. While it is high, `rd_data` does not change and later accepted messages are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| deact | input | 1 | Deactivation or failed activation pulse; reinitializes transmit side |
| wr_en | input | 1 | Host write of transmit message |
| wr_data | input | 12 | Transmit message |
| rd_en | input | 1 | Host read of receive message; clears the request |
| rd_data | output | 12 | Presented receive message |
| irq | output | 1 | Interrupt request |
| sync | input | 1 | Line superframe synchronized |
| eoc_en | input | 1 | Receive processing enable |
| val_mode | input | 1 | 0 = accept at once, 1 = three-in-a-row |
| half_sf | input | 1 | Half-superframe strobe |
| bit_en | input | 1 | Field bit-slot strobe |
| tx_bit | output | 1 | Serial transmit bit |
| rx_bit | input | 1 | Serial receive bit |

## Verification
The assertions watch several rules on every cycle:
- the transmit shift register loads on a synchronized half strobe;
- a deactivation reinitializes the transmit message register;
- a request rises only one cycle after an enabled, synchronized extraction;
- a pending request holds with a frozen read value until it is read.

Other behaviour needs the bench's scenarios and its cycle-by-cycle model:
- the serial bit order in both directions;
- the three-in-a-row confirmation with interleaved mismatches;
- the masking of a mode-flag-only change;
- the dropping of changes that arrive while a request is unread.

// File: rtl/eoc_pkg.sv
package eoc_pkg;
    localparam int unsigned EOC_ADDR_W  = 3;
    localparam int unsigned EOC_INFO_W  = 8;
    localparam int unsigned EOC_CONFIRM = 3;
    typedef enum logic { VAL_IMMEDIATE = 1'b0, VAL_TRIPLE = 1'b1 } val_mode_e;
endpackage

// File: rtl/eoc_tx_path.sv
module eoc_tx_path #(
    parameter int unsigned MSG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             deact,
    input  logic             wr_en,
    input  logic [MSG_W-1:0] wr_data,
    input  logic             sync,
    input  logic             half_sf,
    input  logic             bit_en,
    output logic             tx_bit
);
    typedef struct packed {
        logic [MSG_W-1:0] msg;
        logic [MSG_W-1:0] sh;
    } tx_state_t;

    localparam logic [MSG_W-1:0] ONES = '1;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (deact) begin
            st_d.msg = ONES;
            st_d.sh  = ONES;
        end else begin
            if (wr_en) st_d.msg = wr_data;
            if (sync && half_sf)     st_d.sh = st_q.msg;
            else if (sync && bit_en) st_d.sh = {st_q.sh[MSG_W-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.msg <= ONES;
            st_q.sh  <= ONES;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_bit = sync ? st_q.sh[MSG_W-1] : 1'b1;

    AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && half_sf && !deact) |=> (st_q.sh == $past(st_q.msg))); // R4
    AST_DEACT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        deact |=> (st_q.msg == ONES)); // R2
endmodule

// File: rtl/eoc_rx_capture.sv
module eoc_rx_capture #(
    parameter int unsigned MSG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    input  logic             eoc_en,
    input  logic             half_sf,
    input  logic             bit_en,
    input  logic             rx_bit,
    output logic             ext_stb,
    output logic [MSG_W-1:0] ext_msg
);
    typedef struct packed {
        logic [MSG_W-1:0] sh;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync && bit_en) st_d.sh = {st_q.sh[MSG_W-2:0], rx_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.sh <= '1;
        else        st_q    <= st_d;
    end

    assign ext_stb = half_sf && sync && eoc_en;
    assign ext_msg = st_q.sh;

    AST_RX_HOLD_UNSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !sync |=> $stable(st_q.sh)); // R5
endmodule

// File: rtl/eoc_validator.sv
module eoc_validator #(
    parameter int unsigned MSG_W   = 12,
    parameter int unsigned CONFIRM = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    input  logic             val_mode,
    input  logic             ext_stb,
    input  logic [MSG_W-1:0] ext_msg,
    output logic             acc_stb,
    output logic [MSG_W-1:0] acc_msg
);
    import eoc_pkg::*;

    localparam int unsigned CNT_W = $clog2(CONFIRM + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CONFIRM);

    typedef struct packed {
        logic [MSG_W-1:0] prev;
        logic [CNT_W-1:0] cnt;
    } val_state_t;

    val_state_t st_d, st_q;
    logic       acc_c;

    always_comb begin
        st_d  = st_q;
        acc_c = 1'b0;
        if (!sync) begin
            st_d.cnt = '0;
        end else if (ext_stb) begin
            st_d.prev = ext_msg;
            if (val_mode_e'(val_mode) == VAL_IMMEDIATE) begin
                st_d.cnt = '0;
                acc_c    = 1'b1;
            end else begin
                if (st_q.cnt != '0 && ext_msg == st_q.prev)
                    st_d.cnt = (st_q.cnt == CNT_MAX) ? CNT_MAX : st_q.cnt + 1'b1;
                else
                    st_d.cnt = CNT_W'(1);
                acc_c = (st_d.cnt == CNT_MAX);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= '1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_stb = acc_c;
    assign acc_msg = ext_msg;

    AST_TRIPLE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && val_mode) |-> (ext_msg == st_q.prev && st_q.cnt != '0)); // R8
    AST_CNT_CLEAR_UNSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !sync |=> (st_q.cnt == '0)); // R6
endmodule

// File: rtl/eoc_report.sv
module eoc_report #(
    parameter int unsigned MSG_W  = 12,
    parameter int unsigned INFO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_stb,
    input  logic [MSG_W-1:0] acc_msg,
    input  logic             rd_en,
    output logic             irq,
    output logic [MSG_W-1:0] rd_data
);
    localparam int unsigned DM_POS = INFO_W;

    typedef struct packed {
        logic [MSG_W-1:0] shown;
        logic             irq;
    } rep_state_t;

    rep_state_t       st_d, st_q;
    logic [MSG_W-1:0] cmp_mask;
    logic             differs;

    always_comb begin
        cmp_mask         = '1;
        cmp_mask[DM_POS] = 1'b0;
        differs = ((acc_msg ^ st_q.shown) & cmp_mask) != '0;
    end

    always_comb begin
        st_d = st_q;
        if (rd_en) st_d.irq = 1'b0;
        if (acc_stb && differs && !st_q.irq) begin
            st_d.irq   = 1'b1;
            st_d.shown = acc_msg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shown <= '1;
            st_q.irq   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq     = st_q.irq;
    assign rd_data = st_q.shown;

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_en) |=> irq); // R10
    AST_RD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> $stable(rd_data)); // R10
    AST_IRQ_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(acc_stb)); // R9
endmodule

// File: rtl/eoc_msg_handler.sv
module eoc_msg_handler #(
    parameter int unsigned ADDR_W  = eoc_pkg::EOC_ADDR_W,
    parameter int unsigned INFO_W  = eoc_pkg::EOC_INFO_W,
    parameter int unsigned CONFIRM = eoc_pkg::EOC_CONFIRM,
    localparam int unsigned MSG_W  = ADDR_W + 1 + INFO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             deact,
    input  logic             wr_en,
    input  logic [MSG_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [MSG_W-1:0] rd_data,
    output logic             irq,
    input  logic             sync,
    input  logic             eoc_en,
    input  logic             val_mode,
    input  logic             half_sf,
    input  logic             bit_en,
    output logic             tx_bit,
    input  logic             rx_bit
);
    logic             ext_stb;
    logic [MSG_W-1:0] ext_msg;
    logic             acc_stb;
    logic [MSG_W-1:0] acc_msg;

    eoc_tx_path #(.MSG_W(MSG_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .deact(deact), .wr_en(wr_en),
        .wr_data(wr_data), .sync(sync), .half_sf(half_sf),
        .bit_en(bit_en), .tx_bit(tx_bit)
    );

    eoc_rx_capture #(.MSG_W(MSG_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .sync(sync), .eoc_en(eoc_en),
        .half_sf(half_sf), .bit_en(bit_en), .rx_bit(rx_bit),
        .ext_stb(ext_stb), .ext_msg(ext_msg)
    );

    eoc_validator #(.MSG_W(MSG_W), .CONFIRM(CONFIRM)) u_val (
        .clk(clk), .rst_n(rst_n), .sync(sync), .val_mode(val_mode),
        .ext_stb(ext_stb), .ext_msg(ext_msg),
        .acc_stb(acc_stb), .acc_msg(acc_msg)
    );

    eoc_report #(.MSG_W(MSG_W), .INFO_W(INFO_W)) u_rep (
        .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_msg(acc_msg),
        .rd_en(rd_en), .irq(irq), .rd_data(rd_data)
    );

    AST_IRQ_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(sync && eoc_en && half_sf)); // R6
endmodule

// File: tb/eoc_msg_handler_tb.sv
`timescale 1ns/1ps
module eoc_msg_handler_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        deact = 0, wr_en = 0, rd_en = 0, sync = 0, eoc_en = 0;
    logic        val_mode = 0, half_sf = 0, bit_en = 0, rx_bit = 1;
    logic [11:0] wr_data = '0;
    logic [11:0] rd_data;
    logic        irq, tx_bit;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    eoc_msg_handler dut_i (
        .clk(clk), .rst_n(rst_n), .deact(deact), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq),
        .sync(sync), .eoc_en(eoc_en), .val_mode(val_mode),
        .half_sf(half_sf), .bit_en(bit_en), .tx_bit(tx_bit), .rx_bit(rx_bit)
    );

    // behavioural reference model
    int m_msg, m_txsh, m_rxsh, m_shown, m_prev, m_cnt;
    bit m_irq;

    function automatic bit differs(int a, int b);
        return ((a ^ b) & 12'hEFF) != 0;
    endfunction

    always @(posedge clk) begin
        int cand;
        bit acc;
        if (!rst_n) begin
            m_msg = 12'hFFF; m_txsh = 12'hFFF; m_rxsh = 12'hFFF;
            m_shown = 12'hFFF; m_prev = 12'hFFF; m_cnt = 0; m_irq = 0;
        end else begin
            if (deact) begin
                m_msg = 12'hFFF; m_txsh = 12'hFFF;
            end else begin
                if (sync && half_sf) m_txsh = m_msg;
                else if (sync && bit_en) m_txsh = ((m_txsh << 1) | 1) & 12'hFFF;
                if (wr_en) m_msg = wr_data;
            end
            cand = m_rxsh;
            acc = 0;
            if (sync && bit_en) m_rxsh = ((m_rxsh << 1) | rx_bit) & 12'hFFF;
            if (!sync) m_cnt = 0;
            else if (half_sf && eoc_en) begin
                if (!val_mode) begin
                    m_cnt = 0; acc = 1;
                end else begin
                    if (m_cnt > 0 && cand == m_prev) m_cnt = (m_cnt >= 3) ? 3 : m_cnt + 1;
                    else m_cnt = 1;
                    acc = (m_cnt == 3);
                end
                m_prev = cand;
            end
            if (acc && !m_irq && differs(cand, m_shown)) begin
                m_irq = 1; m_shown = cand;
            end else if (rd_en) m_irq = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk("R3 R4 tx_bit model", int'(tx_bit), sync ? ((m_txsh >> 11) & 1) : 1);
            chk("R9 R10 irq model", int'(irq), int'(m_irq));
            chk("R9 rd_data model", int'(rd_data), m_shown);
        end
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic run_half(input logic [11:0] rxm, output logic [11:0] cap);
        @(posedge clk); #1;
        half_sf = 1;
        @(posedge clk); #1;
        half_sf = 0;
        for (int i = 0; i < 12; i++) begin
            cap[11-i] = tx_bit;
            bit_en = 1;
            rx_bit = rxm[11-i];
            @(posedge clk); #1;
        end
        bit_en = 0;
    endtask

    task automatic do_read();
        @(posedge clk); #1; rd_en = 1;
        @(posedge clk); #1; rd_en = 0;
        tick(1);
    endtask

    initial begin
        logic [11:0] cap;
        tick(3);
        rst_n = 1;
        tick(2);
        chk("R2 reset irq", int'(irq), 0);
        chk("R2 reset rd_data", int'(rd_data), 12'hFFF);
        chk("R3 idle tx_bit", int'(tx_bit), 1);

        eoc_en = 1;
        run_half(12'h5A3, cap); run_half(12'h5A3, cap);
        chk("R3 unsync stream", int'(cap), 12'hFFF);
        chk("R6 no extraction unsync", int'(irq), 0);

        sync = 1;
        @(posedge clk); #1; wr_en = 1; wr_data = 12'hC35;
        @(posedge clk); #1; wr_en = 0;
        run_half(12'h9E1, cap);
        chk("R1 R4 tx order", int'(cap), 12'hC35);
        run_half(12'h9E1, cap);
        chk("R4 repeat each half", int'(cap), 12'hC35);
        chk("R7 irq on accept", int'(irq), 1);
        chk("R5 R7 rd_data", int'(rd_data), 12'h9E1);

        run_half(12'h2B4, cap); run_half(12'h2B4, cap);
        chk("R10 frozen while pending", int'(rd_data), 12'h9E1);
        do_read();
        chk("R10 cleared by read", int'(irq), 0);
        run_half(12'h2B4, cap);
        chk("R9 new after read", int'(rd_data), 12'h2B4);
        do_read();

        run_half(12'h3B4, cap); run_half(12'h3B4, cap);
        chk("R9 mode-flag change ignored irq", int'(irq), 0);
        chk("R9 mode-flag change ignored data", int'(rd_data), 12'h2B4);

        eoc_en = 0;
        run_half(12'h777, cap); run_half(12'h777, cap);
        chk("R6 disabled", int'(irq), 0);
        eoc_en = 1; val_mode = 1;

        run_half(12'h6C9, cap); run_half(12'h6C9, cap); run_half(12'h6C9, cap);
        chk("R8 two matches only", int'(irq), 0);
        run_half(12'h777, cap);
        chk("R8 third match irq", int'(irq), 1);
        chk("R8 third match data", int'(rd_data), 12'h6C9);
        do_read();

        run_half(12'h1F0, cap); run_half(12'h1F0, cap); run_half(12'h6C9, cap);
        run_half(12'h1F0, cap); run_half(12'h1F0, cap);
        chk("R8 mismatch restarts", int'(irq), 0);
        run_half(12'h1F0, cap); run_half(12'h000, cap);
        chk("R8 accepted after restart", int'(rd_data), 12'h1F0);
        do_read();

        @(posedge clk); #1; deact = 1;
        @(posedge clk); #1; deact = 0;
        run_half(12'h000, cap);
        chk("R2 deact ones", int'(cap), 12'hFFF);

        tick(4);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule